// File: doc/BRIEF.md
# Receive Buffer and Interrupt Controller

This block stands between a serial receive shift register and the processor's read port. It takes each completed frame as a one-cycle strobe with its byte and stores the byte. It presents the stored bytes to the processor in arrival order and raises the receive interrupt. The storage can be one register, a buffer with a holding stage behind it, or a four-entry FIFO with the same holding stage behind it. The interrupt timing follows the chosen storage. In single mode the interrupt comes with every stored frame. In double mode it comes whenever a byte enters the readable buffer. In FIFO mode it comes after a store or a read that leaves the fill level meeting a programmed threshold.

A controller FSM tracks how full the storage is: `ST_EMPTY`, `ST_PARTIAL`, `ST_FULL` and `ST_HELD`. In `ST_HELD` the storage is full and the holding stage also holds an unread frame. The transitions are:
- **store**: a frame enters the storage. `ST_EMPTY` goes to `ST_PARTIAL` or `ST_FULL`, and `ST_PARTIAL` goes to `ST_FULL`.
- **drain**: a read removes an entry. `ST_PARTIAL` or `ST_FULL` goes down to `ST_EMPTY` or `ST_PARTIAL`.
- **park**: a frame arrives while the storage is full and the holding stage is free. `ST_FULL` goes to `ST_HELD`.
- **refill**: a read pulls the held frame into the storage. `ST_HELD` goes to `ST_FULL`, or stays in `ST_HELD` if a new frame parks in the same cycle.
- **overrun**: a frame arrives while the block is in `ST_HELD`, or while a single register is full, and no read happens in that cycle. The frame is dropped and the state does not change.

A store and a read in the same cycle keep the state where it is.

Top module: `rxb_irq_ctrl`

## Requirements
- R1: The storage mode is decoded from the configuration inputs. `cfg_fifo_en=1` selects the FIFO. Otherwise `cfg_dbl=1` or `cfg_uart=1` selects double mode. Single mode is used only when all three inputs are 0.
- R2: In single mode, a frame that arrives into an empty register drives `fill_level` to 1. `rx_irq` is high for exactly the one cycle after the `frame_done` strobe.
- R3: In double mode, a frame into an empty buffer raises `rx_irq`. A frame that arrives while the buffer is occupied parks in the holding stage, with no interrupt, and `fill_level` stays at 1. The next read moves the parked byte into the buffer and raises `rx_irq` in the cycle after that read.
- R4: The FIFO holds up to 4 entries, and `fill_level` never exceeds 4. A frame that arrives while the FIFO is full parks in the holding stage. A later read refills the FIFO from the holding stage.
- R5: In FIFO mode, the threshold condition is evaluated after every store and after every read of a non-empty FIFO. It is evaluated on the level that results from that cycle. A frame that parks in the holding stage is not an evaluation event.
- R6: With `cfg_ge=0`, a FIFO interrupt requires the resulting level to equal the threshold. With `cfg_ge=1`, it requires the resulting level to be greater than or equal to the threshold.
- R7: A `cfg_thresh` value of 0 means a threshold of 4.
- R8: A frame that arrives with no free space anywhere and no read in the same cycle is discarded. No free space means single mode with the register full, or the storage full with the holding stage occupied. Such a frame sets the sticky `overrun` output and produces no interrupt.
- R9: A read of a non-empty store puts the oldest byte on `rd_data` in the next cycle. A read of an empty store leaves both `rd_data` and `fill_level` unchanged.
- R10: A store and a read in the same cycle leave `fill_level` unchanged. They cause at most one single-cycle interrupt.
- R11: Reset clears `fill_level`, `overrun`, `rd_data`, `rx_irq` and the holding stage.
- R12: `rx_irq` is a registered pulse in the cycle after its event. With no frame strobe and no read, `rx_irq` stays low and `fill_level` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: a frame has completed |
| frame_data | input | DATA_W | Byte of the completed frame |
| cfg_uart | input | 1 | 1 = asynchronous mode, which forbids single mode |
| cfg_dbl | input | 1 | 1 = double mode when the FIFO is off |
| cfg_fifo_en | input | 1 | 1 = four-entry FIFO |
| cfg_thresh | input | TH_W | FIFO interrupt threshold, where 0 means DEPTH |
| cfg_ge | input | 1 | 0 = level equal to threshold, 1 = level at or above threshold |
| rd_en | input | 1 | Processor read strobe |
| rd_data | output | DATA_W | Last byte read |
| fill_level | output | LVL_W | Readable entries, not counting the holding stage |
| overrun | output | 1 | Sticky flag: a frame was lost |
| rx_irq | output | 1 | One-cycle receive interrupt |

## Verification
The assertions assume that the configuration inputs change only while `rst_n` is low. Their checks of level bounds and threshold results compare against the current configuration, so a change out of reset would break them. They also treat every cycle with `frame_done` high as a separate frame. The stimulus sets a new configuration only inside a reset pulse, and then drives frame strobes and reads freely cycle by cycle. It covers all eight configuration combinations, with randomly chosen thresholds and compare modes.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;

    typedef enum logic [1:0] {
        BUF_SINGLE = 2'd0,
        BUF_DOUBLE = 2'd1,
        BUF_FIFO   = 2'd2
    } buf_mode_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2,
        ST_HELD    = 2'd3
    } occ_state_e;

endpackage

// File: rtl/rxb_cfg_decode.sv
`timescale 1ns/1ps
module rxb_cfg_decode
    import rxb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TH_W  = 2,
    parameter int LVL_W = 3
) (
    input  logic             cfg_uart,
    input  logic             cfg_dbl,
    input  logic             cfg_fifo_en,
    input  logic [TH_W-1:0]  cfg_thresh,
    output buf_mode_e        mode,
    output logic [LVL_W-1:0] capacity,
    output logic             hold_ok,
    output logic [LVL_W-1:0] thr_eff
);

    // R1: the FIFO enable wins; asynchronous mode never runs single
    always_comb begin
        if (cfg_fifo_en)
            mode = BUF_FIFO;
        else if (cfg_dbl || cfg_uart)
            mode = BUF_DOUBLE;
        else
            mode = BUF_SINGLE;
    end

    assign capacity = (mode == BUF_FIFO) ? LVL_W'(DEPTH) : LVL_W'(1);
    assign hold_ok  = (mode != BUF_SINGLE);

    // R7: zero (or anything past the depth) means the full depth
    always_comb begin
        if ((cfg_thresh == '0) || (LVL_W'(cfg_thresh) > LVL_W'(DEPTH)))
            thr_eff = LVL_W'(DEPTH);
        else
            thr_eff = LVL_W'(cfg_thresh);
    end

endmodule

// File: rtl/rxb_store.sv
`timescale 1ns/1ps
module rxb_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [DATA_W-1:0] slot_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (push && (wr_ptr_q == PTR_W'(i)))
                slot_q[i] <= wdata;
        end
    end

    assign head = slot_q[rd_ptr_q];

endmodule

// File: rtl/rxb_irq_eval.sv
`timescale 1ns/1ps
module rxb_irq_eval
    import rxb_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  buf_mode_e        mode,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] lvl_next,
    input  logic [LVL_W-1:0] thr_eff,
    input  logic             cmp_ge,
    output logic             irq
);

    logic hit;
    logic fire;

    // R6: equal or at-or-above, chosen by the compare bit
    assign hit = cmp_ge ? (lvl_next >= thr_eff) : (lvl_next == thr_eff);

    // R5: FIFO looks at both events; the others fire on every store
    always_comb begin
        unique case (mode)
            BUF_FIFO:   fire = (push || pop) && hit;
            BUF_SINGLE,
            BUF_DOUBLE: fire = push;
            default:    fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end

endmodule

// File: rtl/rxb_irq_ctrl.sv
`timescale 1ns/1ps
module rxb_irq_ctrl
    import rxb_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 4,
    localparam int TH_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              cfg_uart,
    input  logic              cfg_dbl,
    input  logic              cfg_fifo_en,
    input  logic [TH_W-1:0]   cfg_thresh,
    input  logic              cfg_ge,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  fill_level,
    output logic              overrun,
    output logic              rx_irq
);

    buf_mode_e         mode;
    logic [LVL_W-1:0]  capacity;
    logic              hold_ok;
    logic [LVL_W-1:0]  thr_eff;

    occ_state_e        state_q, state_d;
    logic [LVL_W-1:0]  level_q, lvl_next;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] rd_q;
    logic              ovr_q;

    logic              push, pop, from_hold;
    logic              hold_load, hold_clr, ovr_set;
    logic              held_next;
    logic [DATA_W-1:0] wdata, head;

    rxb_cfg_decode #(
        .DEPTH (DEPTH),
        .TH_W  (TH_W),
        .LVL_W (LVL_W)
    ) u_cfg (
        .cfg_uart    (cfg_uart),
        .cfg_dbl     (cfg_dbl),
        .cfg_fifo_en (cfg_fifo_en),
        .cfg_thresh  (cfg_thresh),
        .mode        (mode),
        .capacity    (capacity),
        .hold_ok     (hold_ok),
        .thr_eff     (thr_eff)
    );

    // Transition and datapath control
    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        from_hold = 1'b0;
        hold_load = 1'b0;
        hold_clr  = 1'b0;
        ovr_set   = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                push = frame_done;                  // store
            end
            ST_PARTIAL: begin
                pop  = rd_en;                       // drain
                push = frame_done;                  // store
            end
            ST_FULL: begin
                pop = rd_en;
                if (frame_done) begin
                    if (rd_en)        push      = 1'b1;   // R10
                    else if (hold_ok) hold_load = 1'b1;   // park
                    else              ovr_set   = 1'b1;   // R8
                end
            end
            ST_HELD: begin
                if (rd_en) begin                    // refill
                    pop       = 1'b1;
                    push      = 1'b1;
                    from_hold = 1'b1;
                    if (frame_done) hold_load = 1'b1;
                    else            hold_clr  = 1'b1;
                end else if (frame_done) begin
                    ovr_set = 1'b1;                 // overrun
                end
            end
            default: ;
        endcase

        lvl_next  = level_q + LVL_W'(push) - LVL_W'(pop);
        held_next = hold_load || ((state_q == ST_HELD) && !hold_clr);

        if (held_next)                state_d = ST_HELD;
        else if (lvl_next == '0)      state_d = ST_EMPTY;
        else if (lvl_next == capacity) state_d = ST_FULL;
        else                          state_d = ST_PARTIAL;
    end

    assign wdata = from_hold ? hold_q : frame_data;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            level_q <= '0;
        end else begin
            state_q <= state_d;
            level_q <= lvl_next;
        end
    end

    // Output and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            rd_q   <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (hold_load) hold_q <= frame_data;
            if (pop)       rd_q   <= head;
            if (ovr_set)   ovr_q  <= 1'b1;
        end
    end

    rxb_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wdata),
        .head  (head)
    );

    rxb_irq_eval #(
        .LVL_W (LVL_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .push     (push),
        .pop      (pop),
        .lvl_next (lvl_next),
        .thr_eff  (thr_eff),
        .cmp_ge   (cfg_ge),
        .irq      (rx_irq)
    );

    assign rd_data    = rd_q;
    assign fill_level = level_q;
    assign overrun    = ovr_q;

endmodule

// File: rtl/rxb_irq_ctrl_chk.sv
`timescale 1ns/1ps
module rxb_irq_ctrl_chk #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 4,
    localparam int TH_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic              rd_en,
    input logic              cfg_uart,
    input logic              cfg_dbl,
    input logic              cfg_fifo_en,
    input logic [TH_W-1:0]   cfg_thresh,
    input logic              cfg_ge,
    input logic [DATA_W-1:0] rd_data,
    input logic [LVL_W-1:0]  fill_level,
    input logic              overrun,
    input logic              rx_irq
);

    logic [LVL_W-1:0] thr;
    logic             single_mode;

    assign thr = (cfg_thresh == '0) ? LVL_W'(DEPTH) : LVL_W'(cfg_thresh);
    assign single_mode = !cfg_fifo_en && !cfg_dbl && !cfg_uart;

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R8
    ovr_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> !rx_irq);

    // R4
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    // R1
    nonfifo_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |-> (fill_level <= LVL_W'(1)));

    // R6
    eq_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && cfg_fifo_en && !cfg_ge) |-> (fill_level == thr));

    // R6
    ge_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && cfg_fifo_en && cfg_ge) |-> (fill_level >= thr));

    // R9
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (fill_level == '0) && !frame_done) |=> ($stable(rd_data) && (fill_level == '0)));

    // R2
    single_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && single_mode && (fill_level == '0)) |=> (rx_irq && (fill_level == LVL_W'(1))));

    // R12
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !rd_en) |=> (!rx_irq && $stable(fill_level)));

endmodule

bind rxb_irq_ctrl rxb_irq_ctrl_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .rd_en       (rd_en),
    .cfg_uart    (cfg_uart),
    .cfg_dbl     (cfg_dbl),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_thresh  (cfg_thresh),
    .cfg_ge      (cfg_ge),
    .rd_data     (rd_data),
    .fill_level  (fill_level),
    .overrun     (overrun),
    .rx_irq      (rx_irq)
);

// File: tb/rxb_irq_ctrl_bench.sv
`timescale 1ns/1ps
module rxb_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 4;
    localparam int TH_W       = 2;
    localparam int LVL_W      = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              frame_done;
    logic [DATA_W-1:0] frame_data;
    logic              cfg_uart, cfg_dbl, cfg_fifo_en, cfg_ge;
    logic [TH_W-1:0]   cfg_thresh;
    logic              rd_en;
    logic [DATA_W-1:0] rd_data;
    logic [LVL_W-1:0]  fill_level;
    logic              overrun;
    logic              rx_irq;

    int n_chk  = 0;
    int n_fail = 0;

    // reference state, built from the requirements
    logic [7:0] mq[$];
    bit         m_held;
    logic [7:0] m_hdata;
    bit         m_ovr;
    logic [7:0] m_rd;
    bit         m_irq;
    int         m_mode;   // 0 single, 1 double, 2 fifo
    int         m_thr;
    bit         m_ge;

    rxb_irq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxb_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .frame_data  (frame_data),
        .cfg_uart    (cfg_uart),
        .cfg_dbl     (cfg_dbl),
        .cfg_fifo_en (cfg_fifo_en),
        .cfg_thresh  (cfg_thresh),
        .cfg_ge      (cfg_ge),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .fill_level  (fill_level),
        .overrun     (overrun),
        .rx_irq      (rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_hit(input int lvl);
        int th;
        th = (m_thr == 0) ? DEPTH : m_thr;          // R7
        return m_ge ? (lvl >= th) : (lvl == th);    // R6
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " fill_level"}, int'(fill_level), mq.size());
        chk({tag, " R12 rx_irq"}, int'(rx_irq), int'(m_irq));
        chk({tag, " R8 overrun"}, int'(overrun), int'(m_ovr));
        chk({tag, " R9 rd_data"}, int'(rd_data), int'(m_rd));
    endtask

    task automatic do_reset(input bit u, input bit d, input bit f,
                            input logic [1:0] th, input bit ge, input string tag);
        cfg_uart = u; cfg_dbl = d; cfg_fifo_en = f; cfg_thresh = th; cfg_ge = ge;
        frame_done = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
        m_mode = f ? 2 : ((d || u) ? 1 : 0);        // R1
        m_thr = int'(th); m_ge = ge;
        mq.delete(); m_held = 0; m_hdata = '0; m_ovr = 0; m_rd = '0; m_irq = 0;
        @(negedge clk);
        @(negedge clk);
        compare({tag, " R11 reset"});
        rst_n = 1'b1;
    endtask

    task automatic cycle(input bit f, input logic [7:0] d, input bit r, input string tag);
        int cap;
        bit rdok, full, push;
        frame_done = f; frame_data = d; rd_en = r;
        cap  = (m_mode == 2) ? DEPTH : 1;
        rdok = r && (mq.size() > 0);
        full = (mq.size() == cap);
        push = 0;
        if (rdok) m_rd = mq.pop_front();
        if (rdok && m_held) begin
            mq.push_back(m_hdata); push = 1;
            if (f) m_hdata = d; else m_held = 0;
        end else if (f && (!full || rdok)) begin
            mq.push_back(d); push = 1;
        end else if (f && full && (m_mode != 0) && !m_held) begin
            m_held = 1; m_hdata = d;
        end else if (f) begin
            m_ovr = 1;
        end
        m_irq = (m_mode == 2) ? ((push || rdok) && m_hit(mq.size())) : push;
        @(posedge clk);
        @(negedge clk);
        frame_done = 1'b0; rd_en = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        rst_n = 1'b0; frame_done = 1'b0; frame_data = '0; rd_en = 1'b0;
        cfg_uart = 0; cfg_dbl = 0; cfg_fifo_en = 0; cfg_thresh = '0; cfg_ge = 0;
        @(negedge clk);

        // R2 single register, then R8 overrun, then R9 reads
        do_reset(0, 0, 0, 2'd0, 0, "R11");
        cycle(1, 8'hA5, 0, "R2 single store");
        cycle(0, 8'h00, 0, "R12 pulse ends");
        cycle(1, 8'h3C, 0, "R8 single overrun");
        cycle(0, 8'h00, 1, "R9 read");
        cycle(0, 8'h00, 1, "R9 empty read");
        cycle(1, 8'h5A, 1, "R10 single push on empty");

        // R1 asynchronous mode forces double; R3 park and refill
        do_reset(1, 0, 0, 2'd0, 0, "R11");
        cycle(1, 8'h11, 0, "R3 buffer store");
        cycle(1, 8'h22, 0, "R1 R3 park");
        cycle(0, 8'h00, 1, "R3 refill read");
        cycle(0, 8'h00, 1, "R3 final read");
        cycle(0, 8'h00, 0, "R12 idle");

        // R4 R5 R6 FIFO equal-threshold
        do_reset(0, 0, 1, 2'd2, 0, "R11");
        for (int i = 1; i <= 4; i++) cycle(1, 8'(i), 0, "R5 R6 fifo fill");
        cycle(1, 8'h55, 0, "R4 park when full");
        cycle(1, 8'h66, 0, "R8 fifo overrun");
        cycle(0, 8'h00, 1, "R4 refill");
        cycle(0, 8'h00, 1, "R5 read to 3");
        cycle(0, 8'h00, 1, "R5 read to 2");
        cycle(0, 8'h00, 1, "R5 read to 1");
        cycle(1, 8'h77, 1, "R10 push and read");

        // R7 threshold zero means four
        do_reset(0, 0, 1, 2'd0, 0, "R11");
        for (int i = 0; i < 5; i++) cycle(1, 8'(8'h40 + i), 0, "R7 threshold zero");

        // R6 at-or-above, R10 simultaneous events
        do_reset(0, 1, 1, 2'd1, 1, "R11");
        cycle(1, 8'h81, 0, "R6 ge");
        cycle(1, 8'h82, 0, "R6 ge");
        cycle(1, 8'h83, 1, "R10 same cycle");
        cycle(0, 8'h00, 0, "R10 single pulse");

        // R11 reset in mid-stream
        do_reset(0, 0, 1, 2'd3, 0, "R11");
        for (int i = 0; i < 6; i++) cycle(1, 8'(8'h90 + i), 0, "R4 fill");
        do_reset(0, 0, 1, 2'd3, 0, "R11 mid-stream");

        // random phases over every configuration
        for (int c = 0; c < 8; c++) begin
            do_reset(1'(c & 1), 1'((c >> 1) & 1), 1'((c >> 2) & 1),
                     2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), "R11");
            for (int k = 0; k < 350; k++)
                cycle($urandom_range(99, 0) < 45, 8'($urandom),
                      $urandom_range(99, 0) < 35, "R1 R3 R5 R6 R10 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule